// File: doc/BRIEF.md
# Ethernet TX Source Address Inserter

This stage sits directly in front of a transmit MAC on a 64-bit streaming path. Bytes are ordered big-endian within a beat, and each beat carries start-of-packet, end-of-packet and a per-packet skip flag beside a valid/ready handshake. Its main job is to overwrite the 48-bit source MAC address of each outgoing frame with a configured station address. The address field spans two consecutive beats.

A static parameter selects the framing. With client preamble enabled, the first beat of a packet is an 8-byte preamble supplied by the client. The stage replaces its leading byte with the start-of-packet control code and forwards the other seven preamble bytes exactly as received, custom values included. With client preamble disabled, the frame starts at the destination address, so the source address field sits one beat earlier.

The skip flag is taken from the start-of-packet beat and applies to the whole packet; when it is high, the address is left alone. The configured address is captured on the start-of-packet beat, so a change in the middle of a frame never produces a field with mixed bytes. Output beats are registered with one cycle of latency, and the ready signal travels back combinationally.

Top module: `eth_tx_sa_inserter`

## Requirements
- R1: While rst_n is low, and on the first cycle after it is released, out_valid is low. No beat is emitted until one has been accepted.
- R2: in_ready is high whenever the output register is empty or out_ready is high. in_ready is low when the output register holds a beat and out_ready is low.
- R3: A beat accepted on cycle N appears on the output on cycle N+1. out_sop, out_eop and out_skip equal the input values of that beat, and beats leave in the order they arrived.
- R4: While out_valid is high and out_ready is low, out_data, out_sop, out_eop and out_skip stay unchanged.
- R5: In client-preamble mode (PREAMBLE_PASS=1), output byte [63:56] of the start-of-packet beat is SOP_CODE (default 0xFB), whatever the skip flag. Bits [55:0] of that beat are forwarded unchanged.
- R6: In client-preamble mode, with insertion active, beat 1 of the packet leaves with bits [15:0] equal to address bits [47:32]. Beat 2 leaves with bits [63:32] equal to address bits [31:0]. All other bits of those beats are unchanged. Beat 0 is the start-of-packet beat.
- R7: With client preamble off (PREAMBLE_PASS=0), insertion writes address bits [47:32] into bits [15:0] of beat 0 and address bits [31:0] into bits [63:32] of beat 1. Beat 0 is otherwise unchanged.
- R8: When in_skip is high on the start-of-packet beat, no beat of that packet has its address bits modified, even if in_skip changes on later beats.
- R9: The inserted address is the value of cfg_src_addr on the cycle the start-of-packet beat is accepted. Changes to cfg_src_addr later in the frame do not affect that frame.
- R10: Beat positions count accepted beats only (in_valid and in_ready both high). Idle or stalled cycles do not move where the field lands.
- R11: A packet that ends before the field is complete is not modified past its end-of-packet beat. Valid beats arriving outside a packet are forwarded unmodified.
- R12: Each accepted beat produces exactly one output beat. The stage generates no beats of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_src_addr | input | 48 | Station address to insert, bit 47 = first byte on the wire |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Stage can take a beat |
| in_data | input | 64 | Upstream beat, byte [63:56] first |
| in_sop | input | 1 | First beat of packet |
| in_eop | input | 1 | Last beat of packet |
| in_skip | input | 1 | Suppress insertion for this packet (read on start-of-packet) |
| out_valid | output | 1 | Downstream beat valid |
| out_ready | input | 1 | MAC accepts a beat |
| out_data | output | 64 | Edited beat |
| out_sop | output | 1 | First beat of packet |
| out_eop | output | 1 | Last beat of packet |
| out_skip | output | 1 | Skip flag forwarded with its beat |

## Verification
The bench targets packets of one and two beats, which end inside or right after the address field. A stage that ignored end-of-packet would corrupt the next stray or idle beat. Random back-pressure and input gaps are applied during the address beats; a tracker that counted cycles instead of accepted beats would write the address one beat late or into the length/type bytes. The bench toggles the skip flag after the start-of-packet beat and rewrites the address register in mid-frame. These catch a stage that reads the flag on every beat, and one whose two field halves come from different address values. Both framing variants receive the same stream, which shows up any offset error between the two layouts.

// File: rtl/eth_sa_pkg.sv
package eth_sa_pkg;

  localparam int unsigned BEAT_W  = 64;
  localparam int unsigned ADDR_W  = 48;
  localparam int unsigned HI_W    = 16;  // address bytes carried in the tail of the first field beat
  localparam int unsigned LO_W    = ADDR_W - HI_W;

  typedef struct packed {
    logic              sop;
    logic              eop;
    logic              skip;
    logic [BEAT_W-1:0] data;
  } beat_t;

  // Replace the leading byte of a beat with the line start code.
  function automatic logic [BEAT_W-1:0] put_start_code(input logic [BEAT_W-1:0] d,
                                                       input logic [7:0] code);
    return {code, d[BEAT_W-9:0]};
  endfunction

  // Upper address bytes go into the lowest bytes of the first field beat.
  function automatic logic [BEAT_W-1:0] put_addr_hi(input logic [BEAT_W-1:0] d,
                                                    input logic [ADDR_W-1:0] a);
    return {d[BEAT_W-1:HI_W], a[ADDR_W-1:LO_W]};
  endfunction

  // Lower address bytes go into the highest bytes of the second field beat.
  function automatic logic [BEAT_W-1:0] put_addr_lo(input logic [BEAT_W-1:0] d,
                                                    input logic [ADDR_W-1:0] a);
    return {a[LO_W-1:0], d[BEAT_W-LO_W-1:0]};
  endfunction

endpackage

// File: rtl/sa_beat_tracker.sv
module sa_beat_tracker
  import eth_sa_pkg::*;
#(
  parameter bit PREAMBLE_PASS = 1'b1,
  parameter bit SA_INSERT     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic              in_skip,
  input  logic [ADDR_W-1:0] cfg_addr,
  output logic              hit_sop_byte,
  output logic              hit_sa_hi,
  output logic              hit_sa_lo,
  output logic [ADDR_W-1:0] addr_cur
);

  localparam int unsigned HI_POS  = PREAMBLE_PASS ? 1 : 0;
  localparam int unsigned LO_POS  = HI_POS + 1;
  localparam int unsigned POS_OUT = LO_POS + 1;           // past the field or outside a packet
  localparam int unsigned POS_W   = $clog2(POS_OUT + 1);

  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  pos_cur;
  logic [POS_W-1:0]  pos_nxt;
  logic              skip_q;
  logic              skip_cur;
  logic [ADDR_W-1:0] addr_q;
  logic              ins_on;

  // A start-of-packet beat always restarts the count at zero.
  assign pos_cur  = in_sop ? '0 : pos_q;
  assign skip_cur = in_sop ? in_skip : skip_q;
  assign addr_cur = in_sop ? cfg_addr : addr_q;
  assign ins_on   = SA_INSERT && !skip_cur;

  always_comb begin
    pos_nxt = pos_q;
    if (fire) begin
      if (in_eop)
        pos_nxt = POS_W'(POS_OUT);
      else if (pos_cur < POS_W'(POS_OUT))
        pos_nxt = pos_cur + POS_W'(1);
      else
        pos_nxt = POS_W'(POS_OUT);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q  <= POS_W'(POS_OUT);
      skip_q <= 1'b1;
      addr_q <= '0;
    end else begin
      pos_q <= pos_nxt;
      if (fire && in_sop) begin
        skip_q <= in_skip;
        addr_q <= cfg_addr;
      end
    end
  end

  generate
    if (PREAMBLE_PASS) begin : g_pre
      assign hit_sop_byte = in_sop;
    end else begin : g_nopre
      assign hit_sop_byte = 1'b0;
    end
  endgenerate

  assign hit_sa_hi = ins_on && (pos_cur == POS_W'(HI_POS));
  assign hit_sa_lo = ins_on && (pos_cur == POS_W'(LO_POS));

endmodule

// File: rtl/sa_field_editor.sv
module sa_field_editor
  import eth_sa_pkg::*;
#(
  parameter logic [7:0] SOP_CODE = 8'hFB
) (
  input  logic [BEAT_W-1:0] in_data,
  input  logic [ADDR_W-1:0] addr,
  input  logic              hit_sop_byte,
  input  logic              hit_sa_hi,
  input  logic              hit_sa_lo,
  output logic [BEAT_W-1:0] edit_data
);

  always_comb begin
    edit_data = in_data;
    if (hit_sop_byte) edit_data = put_start_code(edit_data, SOP_CODE);
    if (hit_sa_hi)    edit_data = put_addr_hi(edit_data, addr);
    if (hit_sa_lo)    edit_data = put_addr_lo(edit_data, addr);
  end

endmodule

// File: rtl/sa_out_stage.sv
module sa_out_stage
  import eth_sa_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  in_valid,
  output logic  in_ready,
  input  beat_t in_beat,
  output logic  out_valid,
  input  logic  out_ready,
  output beat_t out_beat
);

  logic  valid_q;
  beat_t beat_q;

  // Empty or draining this cycle: room for the next beat.
  assign in_ready = out_ready || !valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      beat_q  <= '0;
    end else if (in_ready) begin
      valid_q <= in_valid;
      if (in_valid) beat_q <= in_beat;
    end
  end

  assign out_valid = valid_q;
  assign out_beat  = beat_q;

endmodule

// File: rtl/eth_tx_sa_inserter.sv
module eth_tx_sa_inserter
  import eth_sa_pkg::*;
#(
  parameter bit         PREAMBLE_PASS = 1'b1,
  parameter bit         SA_INSERT     = 1'b1,
  parameter logic [7:0] SOP_CODE      = 8'hFB
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [47:0] cfg_src_addr,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [63:0] in_data,
  input  logic        in_sop,
  input  logic        in_eop,
  input  logic        in_skip,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [63:0] out_data,
  output logic        out_sop,
  output logic        out_eop,
  output logic        out_skip
);

  logic              fire;
  logic              hit_sop_byte;
  logic              hit_sa_hi;
  logic              hit_sa_lo;
  logic [ADDR_W-1:0] addr_cur;
  logic [BEAT_W-1:0] edit_data;
  beat_t             stage_in;
  beat_t             stage_out;

  assign fire = in_valid && in_ready;

  sa_beat_tracker #(
    .PREAMBLE_PASS (PREAMBLE_PASS),
    .SA_INSERT     (SA_INSERT)
  ) u_track (
    .clk          (clk),
    .rst_n        (rst_n),
    .fire         (fire),
    .in_sop       (in_sop),
    .in_eop       (in_eop),
    .in_skip      (in_skip),
    .cfg_addr     (cfg_src_addr),
    .hit_sop_byte (hit_sop_byte),
    .hit_sa_hi    (hit_sa_hi),
    .hit_sa_lo    (hit_sa_lo),
    .addr_cur     (addr_cur)
  );

  sa_field_editor #(
    .SOP_CODE (SOP_CODE)
  ) u_edit (
    .in_data      (in_data),
    .addr         (addr_cur),
    .hit_sop_byte (hit_sop_byte),
    .hit_sa_hi    (hit_sa_hi),
    .hit_sa_lo    (hit_sa_lo),
    .edit_data    (edit_data)
  );

  assign stage_in = '{sop: in_sop, eop: in_eop, skip: in_skip, data: edit_data};

  sa_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_beat   (stage_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_beat  (stage_out)
  );

  assign out_data = stage_out.data;
  assign out_sop  = stage_out.sop;
  assign out_eop  = stage_out.eop;
  assign out_skip = stage_out.skip;

endmodule

// File: rtl/sa_inserter_checker.sv
module sa_inserter_checker #(
  parameter logic [7:0] SOP_CODE = 8'hFB
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic [63:0] in_data,
  input logic        in_sop,
  input logic        in_eop,
  input logic        out_valid,
  input logic        out_ready,
  input logic [63:0] out_data,
  input logic        out_sop,
  input logic        out_eop,
  input logic        fire,
  input logic        hit_sop_byte,
  input logic        hit_sa_hi,
  input logic        hit_sa_lo
);

  a_r2_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  a_r2_ready_follows_sink: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (out_valid && out_sop == $past(in_sop) && out_eop == $past(in_eop)));

  a_r4_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  a_r5_start_code: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_sop_byte) |=> (out_data[63:56] == SOP_CODE && out_data[55:16] == $past(in_data[55:16])));

  a_r6_hi_beat_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_sa_hi && !hit_sop_byte) |=> (out_data[63:16] == $past(in_data[63:16])));

  a_r6_lo_beat_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && hit_sa_lo) |=> (out_data[31:0] == $past(in_data[31:0])));

  a_r10_one_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_sa_hi, hit_sa_lo}));

  a_r11_untouched: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !hit_sop_byte && !hit_sa_hi && !hit_sa_lo) |=> (out_data == $past(in_data)));

endmodule

bind eth_tx_sa_inserter sa_inserter_checker #(
  .SOP_CODE (SOP_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .in_valid     (in_valid),
  .in_ready     (in_ready),
  .in_data      (in_data),
  .in_sop       (in_sop),
  .in_eop       (in_eop),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_data     (out_data),
  .out_sop      (out_sop),
  .out_eop      (out_eop),
  .fire         (fire),
  .hit_sop_byte (hit_sop_byte),
  .hit_sa_hi    (hit_sa_hi),
  .hit_sa_lo    (hit_sa_lo)
);

// File: tb/test_eth_tx_sa_inserter.sv
module test_eth_tx_sa_inserter;

  typedef struct {
    logic [63:0] data;
    logic        sop;
    logic        eop;
    logic        skip;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [47:0] cfg_src_addr = '0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic        in_skip = 1'b0;
  logic        out_ready = 1'b1;

  logic        rdy_p, vld_p, sop_p, eop_p, skp_p;
  logic [63:0] dat_p;
  logic        rdy_n, vld_n, sop_n, eop_n, skp_n;
  logic [63:0] dat_n;

  int vectors = 0;
  int fails = 0;
  int ready_pct = 70;

  exp_t q_p[$];
  exp_t q_n[$];

  // packet-position model
  bit          inframe = 0;
  int          pos = 0;
  bit          pkt_skip = 0;
  logic [47:0] pkt_addr = '0;

  // stall snapshot
  bit          held = 0;
  logic [63:0] held_p, held_n;

  always #4 clk = ~clk;  // 125 MHz

  eth_tx_sa_inserter #(.PREAMBLE_PASS(1'b1)) i_eth_tx_sa_inserter (
    .clk(clk), .rst_n(rst_n), .cfg_src_addr(cfg_src_addr),
    .in_valid(in_valid), .in_ready(rdy_p), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_skip(in_skip),
    .out_valid(vld_p), .out_ready(out_ready), .out_data(dat_p),
    .out_sop(sop_p), .out_eop(eop_p), .out_skip(skp_p));

  eth_tx_sa_inserter #(.PREAMBLE_PASS(1'b0)) i_eth_tx_sa_inserter_np (
    .clk(clk), .rst_n(rst_n), .cfg_src_addr(cfg_src_addr),
    .in_valid(in_valid), .in_ready(rdy_n), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop), .in_skip(in_skip),
    .out_valid(vld_n), .out_ready(out_ready), .out_data(dat_n),
    .out_sop(sop_n), .out_eop(eop_n), .out_skip(skp_n));

  // Expected edit of one beat, written from R5..R8 and R11.
  function automatic logic [63:0] model(bit pre, logic [63:0] d, bit infr, int p,
                                        bit skp, logic [47:0] a);
    logic [63:0] r = d;
    int first = pre ? 1 : 0;
    if (!infr) return r;
    if (pre && p == 0) r[63:56] = 8'hFB;
    if (!skp && p == first)     r[15:0]  = a[47:32];
    if (!skp && p == first + 1) r[63:32] = a[31:0];
    return r;
  endfunction

  function automatic string tag_of(bit pre, bit infr, int p, bit skp);
    int first = pre ? 1 : 0;
    if (!infr) return "R11";
    if (skp) return "R8";
    if (pre && p == 0) return "R5";
    if (p == first || p == first + 1) return pre ? "R6" : "R7";
    return "R3";
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare(input string who, input exp_t e, input logic [63:0] d,
                         input logic s, input logic eo, input logic k);
    check({e.tag, " data ", who}, d, e.data);
    check({"R3 side ", who}, {61'd0, s, eo, k}, {61'd0, e.sop, e.eop, e.skip});
  endtask

  // One clock: drive at the falling edge, then observe what the rising edge will take.
  task automatic cycle(input bit v, input logic [63:0] d, input bit s, input bit e,
                       input bit k, output bit acc);
    exp_t ep, en;
    if (held) begin  // R4: stalled output must not move
      check("R4 hold pre", dat_p, held_p);
      check("R4 hold np", dat_n, held_n);
      check("R4 valid", {63'd0, vld_p}, 64'd1);
      held = 0;
    end
    in_valid = v; in_data = d; in_sop = s; in_eop = e; in_skip = k;
    out_ready = (($urandom % 100) < ready_pct);
    if (($urandom % 6) == 0) cfg_src_addr = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
    #1;
    check("R2 ready", {63'd0, rdy_p}, {63'd0, out_ready || !vld_p});
    check("R2 ready np", {63'd0, rdy_n}, {63'd0, rdy_p});
    if (vld_p && out_ready) begin
      if (q_p.size() == 0) begin fails++; $display("FAIL R12 extra beat actual=1 expected=0"); end
      else begin ep = q_p.pop_front(); compare("pre", ep, dat_p, sop_p, eop_p, skp_p); end
    end
    if (vld_n && out_ready) begin
      if (q_n.size() == 0) begin fails++; $display("FAIL R12 extra beat np actual=1 expected=0"); end
      else begin en = q_n.pop_front(); compare("np", en, dat_n, sop_n, eop_n, skp_n); end
    end
    if (vld_p && !out_ready) begin held = 1; held_p = dat_p; held_n = dat_n; end
    acc = v && rdy_p;
    if (acc) begin
      if (s) begin inframe = 1; pos = 0; pkt_skip = k; pkt_addr = cfg_src_addr; end
      else if (inframe) pos++;
      ep = '{data: model(1, d, inframe, pos, pkt_skip, pkt_addr), sop: s, eop: e, skip: k,
             tag: tag_of(1, inframe, pos, pkt_skip)};
      en = '{data: model(0, d, inframe, pos, pkt_skip, pkt_addr), sop: s, eop: e, skip: k,
             tag: tag_of(0, inframe, pos, pkt_skip)};
      q_p.push_back(ep);
      q_n.push_back(en);
      if (e) inframe = 0;
    end
    @(negedge clk);
  endtask

  task automatic send_beat(input logic [63:0] d, input bit s, input bit e, input bit k,
                           input int gap_pct);
    bit acc;
    while (($urandom % 100) < gap_pct)
      cycle(0, {$urandom, $urandom}, $urandom % 2, $urandom % 2, $urandom % 2, acc);
    acc = 0;
    while (!acc) cycle(1, d, s, e, k, acc);
  endtask

  // R10: gaps and stalls are mixed into every packet.
  task automatic send_pkt(input int len, input bit skip, input bit flip_skip, input int gap_pct);
    for (int b = 0; b < len; b++) begin
      logic [63:0] d = {$urandom, $urandom};
      bit k = (b == 0) ? skip : (flip_skip ? !skip : skip);  // R8: later beats carry the other value
      send_beat(d, b == 0, b == len - 1, k, gap_pct);
    end
  endtask

  task automatic run_all();
    bit acc;
    void'($urandom(32'h5A1D_0C3E));
    rst_n = 1'b0;
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, vld_p | vld_n}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", {63'd0, vld_p | vld_n}, 64'd0);

    // Directed: a custom preamble with standard-looking body
    send_beat(64'h11_55AA_5555_5555_D7, 1, 0, 0, 0);
    send_beat(64'h0102_0304_0506_A1A2, 0, 0, 0, 0);
    send_beat(64'hB1B2_B3B4_0800_CCDD, 0, 1, 0, 0);
    // R11: short packets followed by stray beats
    send_pkt(1, 0, 0, 0);
    send_beat(64'hDEAD_BEEF_0000_1111, 0, 0, 0, 0);
    send_pkt(2, 0, 0, 0);
    send_beat(64'hFEED_FACE_2222_3333, 0, 1, 0, 0);
    // R8: skip flag changes after start of packet
    send_pkt(4, 1, 1, 10);
    send_pkt(4, 0, 1, 10);
    // R10: heavy back-pressure around the field
    ready_pct = 20;
    for (int i = 0; i < 6; i++) send_pkt(3 + i % 3, 0, 0, 40);
    ready_pct = 70;
    // Constrained random: R9 address churn, mixed lengths and skip
    for (int i = 0; i < 300; i++) begin
      send_pkt(1 + $urandom % 8, ($urandom % 4) == 0, $urandom % 2, $urandom % 30);
      if (($urandom % 8) == 0) send_beat({$urandom, $urandom}, 0, $urandom % 2, $urandom % 2, 0);
    end
    // Drain and confirm one output per input (R12)
    ready_pct = 100;
    for (int i = 0; i < 8; i++) cycle(0, '0, 0, 0, 0, acc);
    check("R12 leftover pre", 64'(q_p.size()), 64'd0);
    check("R12 leftover np", 64'(q_n.size()), 64'd0);
  endtask

  initial begin
    @(negedge clk);
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule